// File: doc/BRIEF.md
# Random Word Output Buffer

This block sits at the output of a random-number peripheral. The conditioning core hands it 32-bit words. The block queues those words in a twelve-entry ring and presents the oldest one on a read-data port. Each read strobe removes exactly one word. The data-ready flag is high only when the word at the head can be consumed as good data. Words arrive only while the enable input is high.

Errors travel with the data. When the status unit reports a seed error, every word still held is marked stale, and each stale word reads as zero until it has been drained. Twelve reads equal the full capacity, so recovery without a conditional reset works as follows: the driver discards twelve reads, and every stale word is then gone.

A small state machine tracks the condition of the queue:
- **EMPTY**: no words are held.
- **READY**: the head word is good.
- **TAINT**: the head word is stale.

Transitions are taken on the next-cycle count and the next-cycle stale count:
- **EMPTY→READY**: a word is accepted.
- **READY→TAINT**: a seed error arrives while words are held.
- **TAINT→READY**: the last stale word drains and good words remain.
- **TAINT→EMPTY**, **READY→EMPTY**: the final word is read.
- **TAINT→TAINT**: stale words remain.

Top module: `rng_out_buf`

## Requirements
- R1: After reset, data_ready is 0 and rd_data is 0.
- R2: While enable is 0, a word presented with word_valid is not stored, and the next read returns 0.
- R3: Words leave in arrival order. The head word is on rd_data in the cycle of a read strobe. The strobe removes it at that clock edge, and the next word is on rd_data from the following cycle.
- R4: data_ready is 1 exactly when at least one word is held and the head word is not stale. In every other case, rd_data is 0.
- R5: A read strobe while empty returns 0 and changes nothing. A word pushed afterwards is read back unchanged.
- R6: The buffer holds 12 words. A word offered while all 12 entries are occupied is dropped.
- R7: A seed-error pulse marks every word held after that cycle's read as stale. Each stale word reads as 0, data_ready stays 0 while a stale word is at the head, and a word offered in the seed-error cycle is dropped.
- R8: After a seed error with a full buffer, 12 reads return 0. The buffer is then empty and clean, and newly accepted words read correctly.
- R9: A read strobe in the same cycle as a seed error returns the good head word. Only the remaining words become stale.
- R10: A push and a read in the same cycle both take effect, and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows words from the core to be accepted |
| word_valid | input | 1 | A word is offered on word_in |
| word_in | input | 32 | Random word from the conditioning core |
| rd_strobe | input | 1 | Data-register read; pops one word |
| seed_err | input | 1 | One-cycle seed-error event from the status unit |
| rd_data | output | 32 | Head word, or 0 when empty or stale |
| data_ready | output | 1 | A good word is available |

## Verification
A seed-error event can land in the same cycle as a data-register read, or in the same cycle as an offered word. The bench drives the seed-error pulse together with a read strobe and an offered word. It then expects three things: the strobed read returns the good head word, the offered word never appears, and every word left behind reads as zero. A push combined with a read in one cycle is also driven, and is judged by the order and count of the words that follow.

// File: rtl/rng_ob_pkg.sv
package rng_ob_pkg;
    typedef enum logic [1:0] {
        OB_EMPTY = 2'd0,
        OB_READY = 2'd1,
        OB_TAINT = 2'd2
    } ob_state_e;
endpackage

// File: rtl/rng_ob_store.sv
module rng_ob_store #(
    parameter int W     = 32,
    parameter int DEPTH = 12,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nxt
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb count_nxt = count + CW'(push) - CW'(pop);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count <= count_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/rng_ob_taint.sv
module rng_ob_taint #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          seed_err,
    input  logic          pop,
    input  logic [CW-1:0] count,
    output logic [CW-1:0] taint,
    output logic [CW-1:0] taint_nxt
);
    always_comb begin
        if (seed_err)
            taint_nxt = count - CW'(pop);
        else if (pop && taint != '0)
            taint_nxt = taint - CW'(1);
        else
            taint_nxt = taint;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) taint <= '0;
        else        taint <= taint_nxt;
    end
endmodule

// File: rtl/rng_out_buf.sv
module rng_out_buf
    import rng_ob_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 12,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         word_valid,
    input  logic [W-1:0] word_in,
    input  logic         rd_strobe,
    input  logic         seed_err,
    output logic [W-1:0] rd_data,
    output logic         data_ready
);
    ob_state_e     state, state_nxt;
    logic [W-1:0]  head;
    logic [CW-1:0] count, count_nxt, taint, taint_nxt;
    logic          push_ok, pop_ok;

    assign pop_ok  = rd_strobe && (count != '0);
    assign push_ok = enable && word_valid && !seed_err && (count != CW'(DEPTH));

    rng_ob_store #(.W(W), .DEPTH(DEPTH)) store_i (
        .clk(clk), .rst_n(rst_n), .push(push_ok), .pop(pop_ok), .din(word_in),
        .head(head), .count(count), .count_nxt(count_nxt)
    );

    rng_ob_taint #(.CW(CW)) taint_i (
        .clk(clk), .rst_n(rst_n), .seed_err(seed_err), .pop(pop_ok),
        .count(count), .taint(taint), .taint_nxt(taint_nxt)
    );

    always_comb begin
        if (count_nxt == '0)      state_nxt = OB_EMPTY;
        else if (taint_nxt != '0) state_nxt = OB_TAINT;
        else                      state_nxt = OB_READY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OB_EMPTY;
        else        state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            OB_READY: begin data_ready = 1'b1; rd_data = head; end
            OB_TAINT: begin data_ready = 1'b0; rd_data = '0;   end
            default:  begin data_ready = 1'b0; rd_data = '0;   end
        endcase
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R6
    AST_NO_FILL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> count <= $past(count)); // R2
    AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ok && !push_ok) |=> count == $past(count) - CW'(1)); // R3
    AST_READY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |-> (count != '0 && taint == '0)); // R4
    AST_TAINT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (taint != '0) |-> (rd_data == '0 && !data_ready)); // R7
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && count == '0 && !push_ok) |=> count == '0); // R5
    AST_TAINT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        taint <= count); // R8
endmodule

// File: tb/rng_out_buf_tb_top.sv
module rng_out_buf_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, word_valid = 1'b0, rd_strobe = 1'b0, seed_err = 1'b0;
    logic [31:0] word_in = '0;
    logic [31:0] rd_data;
    logic        data_ready;

    int    n_checks = 0, n_errors = 0;
    string cur_req = "R1";
    bit    done = 0, mon_on = 0;

    logic [31:0] wq[$];
    bit          bq[$];

    always #2 clk = ~clk;

    rng_out_buf dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .word_valid(word_valid),
        .word_in(word_in), .rd_strobe(rd_strobe), .seed_err(seed_err),
        .rd_data(rd_data), .data_ready(data_ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input bit v, input logic [31:0] w, input bit rd, input bit se);
        @(posedge clk); #1;
        word_valid = v; word_in = w; rd_strobe = rd; seed_err = se;
    endtask

    // monitor: compare against the reference queue, then apply this cycle's inputs
    always @(negedge clk) begin
        if (mon_on) begin
            automatic bit good = (wq.size() != 0) && !bq[0];
            automatic int sz = wq.size();
            check({cur_req, " data_ready"}, {31'd0, data_ready}, {31'd0, good});
            check({cur_req, " rd_data"}, rd_data, good ? wq[0] : 32'd0);
            if (rd_strobe && sz != 0) begin void'(wq.pop_front()); void'(bq.pop_front()); end
            if (seed_err) foreach (bq[i]) bq[i] = 1'b1;
            if (enable && word_valid && !seed_err && sz < 12) begin
                wq.push_back(word_in); bq.push_back(1'b0);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 data_ready", {31'd0, data_ready}, 32'd0);
        check("R1 rd_data", rd_data, 32'd0);
        rst_n = 1'b1;
        mon_on = 1;
        // R2: disabled, offered words ignored
        cur_req = "R2";
        for (int i = 0; i < 3; i++) cyc(1, 32'hB000_0001 + i, 0, 0);
        cyc(0, 0, 1, 0);
        cyc(0, 0, 0, 0);
        enable = 1'b1;
        // R3 / R10: order, and push with pop in one cycle
        cur_req = "R3";
        for (int i = 0; i < 4; i++) cyc(1, 32'hA300_0010 + i, 0, 0);
        cur_req = "R10";
        cyc(1, 32'hA300_0020, 1, 0);
        cyc(1, 32'hA300_0021, 1, 0);
        cur_req = "R3";
        for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0);
        // R5: empty read, then push and read back
        cur_req = "R5";
        cyc(0, 0, 1, 0);
        cyc(0, 0, 0, 0);
        cyc(1, 32'hA500_0055, 0, 0);
        cyc(0, 0, 1, 0);
        cyc(0, 0, 0, 0);
        // R6: 13 offered, 12 kept
        cur_req = "R6";
        for (int i = 0; i < 13; i++) cyc(1, 32'hA600_0100 + i, 0, 0);
        for (int i = 0; i < 13; i++) cyc(0, 0, 1, 0);
        // R9 / R7: seed error together with a read and an offered word
        cur_req = "R9";
        for (int i = 0; i < 6; i++) cyc(1, 32'hA900_0200 + i, 0, 0);
        cyc(1, 32'hDEAD_BEEF, 1, 1);
        cur_req = "R7";
        cyc(1, 32'hA700_0300, 0, 0);
        for (int i = 0; i < 6; i++) cyc(0, 0, 1, 0);
        cyc(0, 0, 0, 0);
        // R8: full buffer, seed error, 12 discarded reads
        cur_req = "R8";
        for (int i = 0; i < 12; i++) cyc(1, 32'hA800_0400 + i, 0, 0);
        cyc(0, 0, 0, 1);
        for (int i = 0; i < 12; i++) cyc(0, 0, 1, 0);
        cyc(0, 0, 0, 0);
        cyc(1, 32'hA800_0999, 0, 0);
        cyc(0, 0, 1, 0);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule